// File: doc/BRIEF.md
# UART Interrupt Source and Enable Logic

This block collects the interrupt causes of one serial channel that has 32-byte receive and transmit FIFOs. It merges them into one active-high request line. It keeps an 8-bit enable register that the host writes and reads back through a plain register port. It also reports which pending cause currently has the highest priority, as a 3-bit code. Some causes are levels that come straight from the datapath status: received data available, modem change and receiver overrun. Others are held in sticky flags until the host acknowledges them: transmitter ready, deferred receive errors, a received Xoff, and rising edges on the RTS and CTS pins.

The upper four enable bits belong to an extended feature set. While the unlock input is low they read as zero and have no effect, and writes leave them at zero. The CTS pin is asynchronous, so it is synchronised with two flops before its rising edge is detected. Parity, framing and break errors are reported when the errored byte is popped from the receive FIFO, not when it arrives. Overrun is reported at once.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the enable register reads 0x00, `irq` is 0 and `irq_code` is 0.
- R2: A write stores `en_wdata` into the enable register in the clock cycle of the write. Bits 7:4 are stored and read back only when `ext_unlock` is 1. While `ext_unlock` is 0 those bits read as 0 and enable nothing. Bit map: 0 receive data, 1 transmit ready, 2 line status, 3 modem, 4 sleep (stored only), 5 Xoff, 6 RTS, 7 CTS.
- R3: The receive-data cause follows `rx_fifo_trig` when `fifo_mode` is 1 and `rx_hold_full` when it is 0. It is combinational, with no delay.
- R4: The transmit condition is `tx_fifo_low` in FIFO mode and `thr_empty` otherwise. A rising edge of that condition sets the transmit-ready flag at the next clock edge. `status_rd` or `tx_hold_wr` clears the flag at the next clock edge. A set in the same cycle wins over a clear.
- R5: A write that changes enable bit 1 from 0 to 1 while the transmit condition is 1 sets the transmit-ready flag at that same clock edge.
- R6: The line-status cause is `overrun` (combinational) OR a sticky error flag. That flag is set at the clock edge of an `rx_pop` whose `rx_pop_err` is non-zero, and cleared at the clock edge of `line_stat_rd`.
- R7: The modem cause follows `modem_delta` combinationally.
- R8: A rising edge on `xoff_seen` sets a sticky Xoff flag at that clock edge. `status_rd` clears it.
- R9: A low-to-high transition of `rts_pin_n` sets the RTS flag at the next clock edge. A low-to-high transition of `cts_pin_n` sets the CTS flag at the third clock edge after it, because of the two synchroniser flops. Both flags are cleared by `status_rd`, and a set wins over a clear.
- R10: `irq_code` gives the highest-priority enabled pending cause: 1 line status, 2 receive data, 3 transmit ready, 4 modem, 5 Xoff, 6 RTS or CTS pin. Priority follows that numbering, lowest code first. The code is 0 when nothing is pending.
- R11: `irq` is the OR of all enabled pending causes. A cause whose enable bit is 0 never raises `irq`, but a sticky flag it sets is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_unlock | input | 1 | Unlocks enable bits 7:4 |
| fifo_mode | input | 1 | 1 selects FIFO-level causes |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Effective enable register value |
| status_rd | input | 1 | Host read of interrupt status |
| tx_hold_wr | input | 1 | Host write of the transmit holding register |
| line_stat_rd | input | 1 | Host read of line status |
| rx_hold_full | input | 1 | Receive holding register has a character |
| rx_fifo_trig | input | 1 | Receive FIFO at or above its trigger level |
| thr_empty | input | 1 | Transmit holding register empty |
| tx_fifo_low | input | 1 | Transmit FIFO below its trigger level |
| overrun | input | 1 | Receiver overrun status |
| rx_pop | input | 1 | A byte is read out of the receive FIFO |
| rx_pop_err | input | 3 | Parity, framing and break flags of the popped byte |
| modem_delta | input | 1 | Some modem status change is pending |
| xoff_seen | input | 1 | Received Xoff pulse |
| rts_pin_n | input | 1 | RTS pin level, active low |
| cts_pin_n | input | 1 | CTS pin level, asynchronous, active low |
| irq | output | 1 | Interrupt request, active high |
| irq_code | output | 3 | Highest-priority pending cause |

## Verification
Each result has its own latency. Enable readback, the receive-data, modem and overrun causes, and the priority code follow their inputs in the same cycle. The transmit, Xoff, RTS and deferred-error flags appear one edge after their trigger. CTS appears three edges after its pin rises. The bench keeps a cycle-accurate reference built from these rules. It applies stimulus one time unit after a rising edge, advances the reference across the next edge, and compares all outputs one time unit after that edge. Same-cycle and registered results are therefore both checked at the point where they are due. Directed sequences check every latency in isolation, and a seeded random phase mixes acknowledges with new causes.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int EN_W      = 8;
  localparam int EXT_LSB   = 4;
  localparam int N_CAUSE   = 6;
  localparam int CODE_W    = 3;
  localparam int ERR_W     = 3;

  localparam int EB_RXD    = 0;
  localparam int EB_TXR    = 1;
  localparam int EB_LINE   = 2;
  localparam int EB_MODEM  = 3;
  localparam int EB_XOFF   = 5;
  localparam int EB_RTS    = 6;
  localparam int EB_CTS    = 7;

  typedef enum logic [CODE_W-1:0] {
    SRC_NONE  = 3'd0,
    SRC_LINE  = 3'd1,
    SRC_RXD   = 3'd2,
    SRC_TXR   = 3'd3,
    SRC_MODEM = 3'd4,
    SRC_XOFF  = 3'd5,
    SRC_PIN   = 3'd6
  } irq_src_e;
endpackage

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int W   = 8,
  parameter int EXT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         unlock,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_eff
);
  localparam logic [W-1:0] BASE_MASK = (W'(1) << EXT) - W'(1);

  logic [W-1:0] mask;
  logic [W-1:0] en_q;

  assign mask   = unlock ? {W{1'b1}} : BASE_MASK;
  assign en_eff = en_q & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= '0;
    else if (wr) en_q <= wdata & mask;
  end

  // R2: an unlocked write reads back whole on the next cycle while still unlocked
  p_write_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && unlock) |=> (!unlock || en_eff == $past(wdata)));
  // R2: a locked write never exposes upper bits
  p_locked_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !unlock) |=> (en_eff[W-1:EXT] == '0 || unlock));
endmodule

// File: rtl/irq_edge_sticky.sv
module irq_edge_sticky #(
  parameter int   SYNC = 0,
  parameter logic IDLE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  input  logic force_set,
  input  logic clr,
  output logic pend
);
  logic sig_s;
  logic prev_q;
  logic set;

  generate
    if (SYNC > 0) begin : g_sync
      logic [SYNC-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= {SYNC{IDLE}};
        else begin
          sync_q[0] <= sig_in;
          for (int i = 1; i < SYNC; i++) sync_q[i] <= sync_q[i-1];
        end
      end
      assign sig_s = sync_q[SYNC-1];
    end else begin : g_direct
      assign sig_s = sig_in;
    end
  endgenerate

  assign set = (sig_s & ~prev_q) | force_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= IDLE;
      pend   <= 1'b0;
    end else begin
      prev_q <= sig_s;
      if (set)      pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end

  // R9: a detected edge or forced set is captured
  p_edge_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> pend);
  // R4: an acknowledge without a new set empties the flag
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !pend);
endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import uart_irq_pkg::*;
#(
  parameter int N = N_CAUSE
) (
  input  logic [N-1:0]      cause,
  output logic              irq,
  output logic [CODE_W-1:0] code
);
  logic [N-1:0] grant;

  always_comb begin
    grant = '0;
    code  = SRC_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (cause[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        code = CODE_W'(i + 1);
      end
    end
  end

  assign irq = |cause;

  always_comb begin
    // R10: at most one cause is reported, and a request always carries a code
    p_one_grant_r10: assert ($onehot0(grant));
    p_code_when_irq_r10: assert (irq == (code != SRC_NONE));
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_unlock,
  input  logic             fifo_mode,
  input  logic             en_wr,
  input  logic [EN_W-1:0]  en_wdata,
  output logic [EN_W-1:0]  en_rdata,
  input  logic             status_rd,
  input  logic             tx_hold_wr,
  input  logic             line_stat_rd,
  input  logic             rx_hold_full,
  input  logic             rx_fifo_trig,
  input  logic             thr_empty,
  input  logic             tx_fifo_low,
  input  logic             overrun,
  input  logic             rx_pop,
  input  logic [ERR_W-1:0] rx_pop_err,
  input  logic             modem_delta,
  input  logic             xoff_seen,
  input  logic             rts_pin_n,
  input  logic             cts_pin_n,
  output logic             irq,
  output logic [CODE_W-1:0] irq_code
);
  logic [EN_W-1:0]    en;
  logic               tx_cond, tx_force, tx_pend;
  logic               xoff_pend, rts_pend, cts_pend;
  logic               err_q, rx_lvl, line_lvl;
  logic [N_CAUSE-1:0] cause;

  irq_en_reg #(.W(EN_W), .EXT(EXT_LSB)) u_en (
    .clk(clk), .rst_n(rst_n), .unlock(ext_unlock),
    .wr(en_wr), .wdata(en_wdata), .en_eff(en)
  );
  assign en_rdata = en;

  assign tx_cond  = fifo_mode ? tx_fifo_low : thr_empty;
  assign tx_force = en_wr && en_wdata[EB_TXR] && !en[EB_TXR] && tx_cond;

  irq_edge_sticky #(.SYNC(0), .IDLE(1'b1)) u_tx (
    .clk(clk), .rst_n(rst_n), .sig_in(tx_cond), .force_set(tx_force),
    .clr(status_rd | tx_hold_wr), .pend(tx_pend)
  );
  irq_edge_sticky #(.SYNC(0), .IDLE(1'b0)) u_xoff (
    .clk(clk), .rst_n(rst_n), .sig_in(xoff_seen), .force_set(1'b0),
    .clr(status_rd), .pend(xoff_pend)
  );
  irq_edge_sticky #(.SYNC(0), .IDLE(1'b1)) u_rts (
    .clk(clk), .rst_n(rst_n), .sig_in(rts_pin_n), .force_set(1'b0),
    .clr(status_rd), .pend(rts_pend)
  );
  irq_edge_sticky #(.SYNC(2), .IDLE(1'b1)) u_cts (
    .clk(clk), .rst_n(rst_n), .sig_in(cts_pin_n), .force_set(1'b0),
    .clr(status_rd), .pend(cts_pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   err_q <= 1'b0;
    else if (rx_pop && |rx_pop_err) err_q <= 1'b1;
    else if (line_stat_rd)        err_q <= 1'b0;
  end

  assign rx_lvl   = fifo_mode ? rx_fifo_trig : rx_hold_full;
  assign line_lvl = overrun | err_q;

  assign cause[SRC_LINE-1]  = line_lvl    & en[EB_LINE];
  assign cause[SRC_RXD-1]   = rx_lvl      & en[EB_RXD];
  assign cause[SRC_TXR-1]   = tx_pend     & en[EB_TXR];
  assign cause[SRC_MODEM-1] = modem_delta & en[EB_MODEM];
  assign cause[SRC_XOFF-1]  = xoff_pend   & en[EB_XOFF];
  assign cause[SRC_PIN-1]   = (rts_pend & en[EB_RTS]) | (cts_pend & en[EB_CTS]);

  irq_prio #(.N(N_CAUSE)) u_prio (
    .cause(cause), .irq(irq), .code(irq_code)
  );

  // R5: enabling transmit-ready while the condition holds requests at once
  p_tx_enable_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_force |=> irq);
  // R6: an enabled overrun always wins the code
  p_overrun_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && en[EB_LINE]) |-> (irq_code == SRC_LINE));
  // R11: nothing enabled means no request
  p_no_enable_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);
  // R6: an errored pop leaves the line cause pending
  p_err_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && |rx_pop_err) |=> line_lvl);
endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_unlock = 0, fifo_mode = 0, en_wr = 0;
  logic [7:0] en_wdata = 0;
  logic status_rd = 0, tx_hold_wr = 0, line_stat_rd = 0;
  logic rx_hold_full = 0, rx_fifo_trig = 0, thr_empty = 0, tx_fifo_low = 0;
  logic overrun = 0, rx_pop = 0;
  logic [2:0] rx_pop_err = 0;
  logic modem_delta = 0, xoff_seen = 0, rts_pin_n = 1, cts_pin_n = 1;
  logic [7:0] en_rdata;
  logic irq;
  logic [2:0] irq_code;

  int checks = 0, errors = 0;

  // reference state
  bit [7:0] m_en;
  bit m_tx, m_txp, m_xoff, m_xp, m_rts, m_rp, m_cts, m_c1, m_c2, m_cp, m_err;

  always #4 clk = ~clk;

  uart_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_unlock(ext_unlock), .fifo_mode(fifo_mode),
    .en_wr(en_wr), .en_wdata(en_wdata), .en_rdata(en_rdata),
    .status_rd(status_rd), .tx_hold_wr(tx_hold_wr), .line_stat_rd(line_stat_rd),
    .rx_hold_full(rx_hold_full), .rx_fifo_trig(rx_fifo_trig),
    .thr_empty(thr_empty), .tx_fifo_low(tx_fifo_low), .overrun(overrun),
    .rx_pop(rx_pop), .rx_pop_err(rx_pop_err), .modem_delta(modem_delta),
    .xoff_seen(xoff_seen), .rts_pin_n(rts_pin_n), .cts_pin_n(cts_pin_n),
    .irq(irq), .irq_code(irq_code)
  );

  function automatic bit [7:0] mask_f();
    return ext_unlock ? 8'hFF : 8'h0F;
  endfunction

  function automatic bit [7:0] exp_en();
    return m_en & mask_f();
  endfunction

  function automatic bit [5:0] exp_cause();
    bit [7:0] e = exp_en();
    bit rx = fifo_mode ? rx_fifo_trig : rx_hold_full;
    return {(m_rts & e[6]) | (m_cts & e[7]), m_xoff & e[5], modem_delta & e[3],
            m_tx & e[1], rx & e[0], (overrun | m_err) & e[2]};
  endfunction

  function automatic bit [2:0] exp_code();
    bit [5:0] c = exp_cause();
    for (int i = 0; i < 6; i++) if (c[i]) return 3'(i + 1);
    return 3'd0;
  endfunction

  task automatic compare(input string tag);
    bit [7:0] ee = exp_en();
    bit ei = |exp_cause();
    bit [2:0] ec = exp_code();
    checks++;
    if (en_rdata !== ee || irq !== ei || irq_code !== ec) begin
      errors++;
      $display("FAIL %s: en=%h irq=%b code=%0d expected en=%h irq=%b code=%0d",
               tag, en_rdata, irq, irq_code, ee, ei, ec);
    end
  endtask

  // advance the reference across one edge, then compare after it
  task automatic step(input string tag);
    bit txc = fifo_mode ? tx_fifo_low : thr_empty;
    bit frc = en_wr && en_wdata[1] && !exp_en()[1] && txc;
    bit crise = m_c2 & ~m_cp;
    if ((txc & ~m_txp) | frc) m_tx = 1; else if (status_rd | tx_hold_wr) m_tx = 0;
    m_txp = txc;
    if (xoff_seen & ~m_xp) m_xoff = 1; else if (status_rd) m_xoff = 0;
    m_xp = xoff_seen;
    if (rts_pin_n & ~m_rp) m_rts = 1; else if (status_rd) m_rts = 0;
    m_rp = rts_pin_n;
    if (crise) m_cts = 1; else if (status_rd) m_cts = 0;
    m_cp = m_c2; m_c2 = m_c1; m_c1 = cts_pin_n;
    if (rx_pop && |rx_pop_err) m_err = 1; else if (line_stat_rd) m_err = 0;
    if (en_wr) m_en = en_wdata & mask_f();
    @(posedge clk); #1;
    compare(tag);
    en_wr = 0; status_rd = 0; tx_hold_wr = 0; line_stat_rd = 0; rx_pop = 0;
    xoff_seen = 0;
  endtask

  task automatic wr_en(input bit [7:0] d);
    en_wr = 1; en_wdata = d;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed = 32'd1357;
    m_en = 0; m_tx = 0; m_txp = 1; m_xoff = 0; m_xp = 0; m_rts = 0; m_rp = 1;
    m_cts = 0; m_c1 = 1; m_c2 = 1; m_cp = 1; m_err = 0;
    #20;
    compare("R1 in reset");
    @(posedge clk); #1; rst_n = 1;
    step("R1 after reset");

    // R2 gating of the extended bits
    wr_en(8'hFF); step("R2 locked write");
    ext_unlock = 1; step("R2 unlock shows nothing stored");
    wr_en(8'hF5); step("R2 unlocked write");
    ext_unlock = 0; step("R2 relock hides upper");
    wr_en(8'h00); step("R2 clear");

    // R3 receive data source selection
    wr_en(8'h01); rx_hold_full = 1; step("R3 holding full");
    fifo_mode = 1; step("R3 fifo mode below trigger");
    rx_fifo_trig = 1; step("R3 fifo at trigger");
    rx_fifo_trig = 0; rx_hold_full = 0; fifo_mode = 0; step("R3 idle");

    // R4 / R5 transmit ready
    thr_empty = 1; step("R4 edge while disabled R11");
    status_rd = 1; step("R4 status read clears");
    wr_en(8'h02); step("R5 enable while empty");
    tx_hold_wr = 1; thr_empty = 0; step("R4 write clears");
    thr_empty = 1; step("R4 edge sets");
    status_rd = 1; step("R4 read clears");

    // R6 line status
    wr_en(8'h07); overrun = 1; rx_hold_full = 1; step("R6 overrun first R10");
    overrun = 0; rx_pop = 1; rx_pop_err = 3'b010; step("R6 errored pop");
    rx_pop_err = 0; step("R6 held");
    line_stat_rd = 1; step("R6 line read clears");
    rx_hold_full = 0; wr_en(8'h08); modem_delta = 1; step("R7 modem");
    modem_delta = 0; step("R7 modem gone");

    // R8 / R9 extended causes
    ext_unlock = 1; wr_en(8'hE0); xoff_seen = 1; step("R8 xoff pulse");
    step("R8 xoff held");
    status_rd = 1; step("R8 read clears");
    rts_pin_n = 0; step("R9 rts low");
    rts_pin_n = 1; step("R9 rts rise");
    status_rd = 1; step("R9 rts clear");
    cts_pin_n = 0; step("R9 cts low"); step("R9 cts low"); step("R9 cts low");
    cts_pin_n = 1; step("R9 cts sync 1"); step("R9 cts sync 2");
    step("R9 cts third edge");
    status_rd = 1; step("R9 cts clear");

    // R10 R11 random mix
    void'($urandom(seed));
    for (int i = 0; i < 600; i++) begin
      ext_unlock   = ($urandom % 4) != 0;
      fifo_mode    = $urandom % 2;
      if ($urandom % 8 == 0) wr_en(8'($urandom));
      status_rd    = ($urandom % 6) == 0;
      tx_hold_wr   = ($urandom % 8) == 0;
      line_stat_rd = ($urandom % 7) == 0;
      rx_hold_full = $urandom % 2;
      rx_fifo_trig = $urandom % 2;
      thr_empty    = ($urandom % 3) == 0;
      tx_fifo_low  = ($urandom % 3) == 0;
      overrun      = ($urandom % 10) == 0;
      rx_pop       = ($urandom % 4) == 0;
      rx_pop_err   = ($urandom % 3) == 0 ? 3'($urandom) : 3'd0;
      modem_delta  = ($urandom % 5) == 0;
      xoff_seen    = ($urandom % 9) == 0;
      if ($urandom % 4 == 0) rts_pin_n = ~rts_pin_n;
      if ($urandom % 4 == 0) cts_pin_n = ~cts_pin_n;
      step("R10 R11 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule